// File: doc/BRIEF.md
# Dual-Channel UART Host Register Interface

This block is the host-facing register front end of a two-channel UART. A host reaches it over an 8-bit parallel bus with an active-low select, active-low read and write strobes and a 3-bit register address; a channel-select input steers every access to the register bank of channel A or channel B. The bus is asynchronous to the block, so the three control strobes are brought into the internal clock domain through two-flop synchronizers, and a write takes effect when the write strobe is released.

Each channel holds a line-control register, a 16-bit divisor latch split into low and high bytes, and a two-bit alternate-function field that chooses what the channel's multifunction output pin carries. When the divisor-access bit of the line-control register is set and the divisor is all zero, the two divisor addresses return a fixed revision code and a fixed device identity instead. Baud generation, FIFOs and modem lines are outside this block; their pin-level signals arrive as stub inputs.

Top module: `duart_host_regs`

## Requirements
- R1: After reset every channel has line control 0x00, divisor low and high 0x00 and alternate-function code 00; the read-data enable is low and each multifunction pin follows its OP2 stub input.
- R2: Address 3 writes and reads the line-control register of the selected channel, all 8 bits.
- R3: With line-control bit 7 set and a nonzero divisor, address 0 accesses the divisor low byte and address 1 the divisor high byte.
- R4: With line-control bit 7 set and both divisor bytes 0x00, address 0 reads the revision code 0x01 and address 1 reads the device identity 0x02.
- R5: chsel = 0 selects channel A and chsel = 1 channel B; a write changes only the selected channel and a read returns data only from the selected channel.
- R6: While cs_n is high, strobes have no effect: no register changes and the read-data enable stays low.
- R7: rdata_oe is high only while cs_n and rd_n are both low (after two clocks of synchronization); while it is low rdata is 0x00.
- R8: A write commits once, after the write strobe is released; while rd_n... while wr_n is still held low the register keeps its old value.
- R9: Each multifunction pin carries, by code: 00 the OP2 stub, 01 the baud-clock stub, 10 the receive-ready stub, 11 a constant high.
- R10: With line-control bit 7 set, address 2 holds the alternate-function code in data bits [1:0] and reads upper bits as zero; addresses 0 to 2 with bit 7 clear, and addresses 4 to 7, read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Active-high asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Register address |
| chsel | input | 1 | Channel select, 0 = A, 1 = B |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host |
| rdata_oe | output | 1 | Read-data drive enable |
| op2_n_i | input | 2 | OP2 stub level per channel |
| baud_n_i | input | 2 | Baud-clock stub level per channel |
| rxrdy_n_i | input | 2 | Receive-ready stub level per channel |
| mf_n | output | 2 | Multifunction pin per channel |

## Verification
Two functions meet in one cycle when a write commit lands on the same clock edge that changes what a read address decodes to: zeroing the last nonzero divisor byte flips address 0 from the divisor to the revision code, and writing the alternate-function code swaps the pin source. The bench provokes this by writing random, often zero, divisor bytes and codes and then reading both divisor addresses and the pins, comparing against a model that applies the identity rule and the pin mux to its own register copy.

// File: rtl/duart_pkg.sv
package duart_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int NUM_CH = 2;

    localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_AFSEL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LINE   = 3'd3;

    typedef enum logic [1:0] {
        AF_OP2   = 2'b00,
        AF_BAUD  = 2'b01,
        AF_RXRDY = 2'b10,
        AF_RSVD  = 2'b11
    } afsel_e;

    typedef struct packed {
        logic [DATA_W-1:0] line;
        logic [DATA_W-1:0] div_lo;
        logic [DATA_W-1:0] div_hi;
        afsel_e            afsel;
    } chan_regs_t;
endpackage

// File: rtl/duart_bus_sync.sv
module duart_bus_sync
    import duart_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chsel,
    input  logic [DATA_W-1:0] wdata,
    output logic              sel_act,
    output logic              rd_act,
    output logic              commit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic              cap_ch,
    output logic [DATA_W-1:0] cap_data
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [TOP:0]      cs_sh;
        logic [TOP:0]      rd_sh;
        logic [TOP:0]      wr_sh;
        logic              wr_prev;
        logic              armed;
        logic [ADDR_W-1:0] addr;
        logic              ch;
        logic [DATA_W-1:0] data;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic cs_low, wr_low, wr_rise;

    always_comb begin
        cs_low  = !st_q.cs_sh[TOP];
        wr_low  = !st_q.wr_sh[TOP];
        wr_rise = st_q.wr_sh[TOP] && !st_q.wr_prev;
        commit  = wr_rise && st_q.armed;

        st_d         = st_q;
        st_d.cs_sh   = {st_q.cs_sh[TOP-1:0], cs_n};
        st_d.rd_sh   = {st_q.rd_sh[TOP-1:0], rd_n};
        st_d.wr_sh   = {st_q.wr_sh[TOP-1:0], wr_n};
        st_d.wr_prev = st_q.wr_sh[TOP];
        if (wr_low && cs_low) begin
            st_d.armed = 1'b1;
            st_d.addr  = addr;
            st_d.ch    = chsel;
            st_d.data  = wdata;
        end else if (commit || !cs_low) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q         <= '0;
            st_q.cs_sh   <= '1;
            st_q.rd_sh   <= '1;
            st_q.wr_sh   <= '1;
            st_q.wr_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_act  = cs_low;
    assign rd_act   = cs_low && !st_q.rd_sh[TOP];
    assign cap_addr = st_q.addr;
    assign cap_ch   = st_q.ch;
    assign cap_data = st_q.data;

    assert_single_commit_R8: assert property (@(posedge clk) disable iff (rst)
        commit |=> !commit);
    assert_commit_after_low_R8: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(!st_q.wr_sh[TOP]));
endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
    import duart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              op2_n,
    input  logic              baud_n,
    input  logic              rxrdy_n,
    output chan_regs_t        regs,
    output logic              mf_n
);
    chan_regs_t regs_d, regs_q;
    logic dlab;

    always_comb begin
        dlab   = regs_q.line[7];
        regs_d = regs_q;
        if (we) begin
            case (waddr)
                A_DIV_LO: if (dlab) regs_d.div_lo = wdata;
                A_DIV_HI: if (dlab) regs_d.div_hi = wdata;
                A_AFSEL:  if (dlab) regs_d.afsel  = afsel_e'(wdata[1:0]);
                A_LINE:   regs_d.line = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    always_comb begin
        case (regs_q.afsel)
            AF_OP2:   mf_n = op2_n;
            AF_BAUD:  mf_n = baud_n;
            AF_RXRDY: mf_n = rxrdy_n;
            default:  mf_n = 1'b1;
        endcase
    end

    assign regs = regs_q;

    assert_unselected_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(regs_q));
    assert_reserved_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (regs_q.afsel == AF_RSVD) |-> mf_n);
    assert_line_follows_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == A_LINE) |=> regs_q.line == $past(wdata));
endmodule

// File: rtl/duart_host_regs.sv
module duart_host_regs
    import duart_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] DEV_ID      = 8'h02,
    parameter logic [DATA_W-1:0] REV_CODE    = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chsel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    input  logic [NUM_CH-1:0] op2_n_i,
    input  logic [NUM_CH-1:0] baud_n_i,
    input  logic [NUM_CH-1:0] rxrdy_n_i,
    output logic [NUM_CH-1:0] mf_n
);
    logic              sel_act, rd_act, commit, cap_ch;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    chan_regs_t        bank [NUM_CH];
    chan_regs_t        cur;
    logic              div_zero;
    logic [DATA_W-1:0] rd_mux;

    duart_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .chsel(chsel), .wdata(wdata),
        .sel_act(sel_act), .rd_act(rd_act), .commit(commit),
        .cap_addr(cap_addr), .cap_ch(cap_ch), .cap_data(cap_data)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        duart_chan_regs u_chan (
            .clk(clk), .rst(rst),
            .we(commit && (cap_ch == c[0])),
            .waddr(cap_addr), .wdata(cap_data),
            .op2_n(op2_n_i[c]), .baud_n(baud_n_i[c]), .rxrdy_n(rxrdy_n_i[c]),
            .regs(bank[c]), .mf_n(mf_n[c])
        );
    end

    always_comb begin
        cur      = bank[chsel];
        div_zero = (cur.div_lo == '0) && (cur.div_hi == '0);
        rd_mux   = '0;
        case (addr)
            A_DIV_LO: if (cur.line[7]) rd_mux = div_zero ? REV_CODE : cur.div_lo;
            A_DIV_HI: if (cur.line[7]) rd_mux = div_zero ? DEV_ID : cur.div_hi;
            A_AFSEL:  if (cur.line[7]) rd_mux = {{(DATA_W-2){1'b0}}, cur.afsel};
            A_LINE:   rd_mux = cur.line;
            default:  rd_mux = '0;
        endcase
        rdata_oe = rd_act;
        rdata    = rd_act ? rd_mux : '0;
    end

    assert_oe_needs_select_R7: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> $past(!cs_n, SYNC_STAGES) && $past(!rd_n, SYNC_STAGES));
    assert_no_commit_unselected_R6: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(sel_act));
    assert_identity_on_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rdata_oe && cur.line[7] && div_zero && addr == A_DIV_HI) |-> rdata == DEV_ID);
endmodule

// File: tb/tb_duart_host_regs.sv
module tb_duart_host_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, chsel = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdata_oe;
    logic [1:0] op2_n_i = 2'b11, baud_n_i = 2'b11, rxrdy_n_i = 2'b11;
    logic [1:0] mf_n;

    int errors = 0;
    int checks = 0;
    logic [7:0] m_line [2];
    logic [7:0] m_lo   [2];
    logic [7:0] m_hi   [2];
    logic [1:0] m_af   [2];

    always #2 clk = ~clk;

    duart_host_regs dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .chsel(chsel), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe), .op2_n_i(op2_n_i), .baud_n_i(baud_n_i),
        .rxrdy_n_i(rxrdy_n_i), .mf_n(mf_n)
    );

    function automatic logic [7:0] exp_read(input int ch, input logic [2:0] a);
        logic dl = m_line[ch][7];
        logic z  = (m_lo[ch] == 8'h00) && (m_hi[ch] == 8'h00);
        case (a)
            3'd0: return dl ? (z ? 8'h01 : m_lo[ch]) : 8'h00;
            3'd1: return dl ? (z ? 8'h02 : m_hi[ch]) : 8'h00;
            3'd2: return dl ? {6'b0, m_af[ch]} : 8'h00;
            3'd3: return m_line[ch];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic exp_pin(input int ch);
        case (m_af[ch])
            2'b00: return op2_n_i[ch];
            2'b01: return baud_n_i[ch];
            2'b10: return rxrdy_n_i[ch];
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_write(input int ch, input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: if (m_line[ch][7]) m_lo[ch] = d;
            3'd1: if (m_line[ch][7]) m_hi[ch] = d;
            3'd2: if (m_line[ch][7]) m_af[ch] = d[1:0];
            3'd3: m_line[ch] = d;
            default: ;
        endcase
    endtask

    task automatic bus_write(input int ch, input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        chsel = ch[0]; addr = a; wdata = d; cs_n = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        model_write(ch, a, d);
    endtask

    task automatic bus_read(input int ch, input logic [2:0] a, output logic [7:0] d,
                            output logic oe);
        @(negedge clk);
        chsel = ch[0]; addr = a; cs_n = 1'b0; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        d = rdata; oe = rdata_oe;
        rd_n = 1'b1; cs_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic read_check(input string req, input int ch, input logic [2:0] a);
        logic [7:0] d; logic oe;
        bus_read(ch, a, d, oe);
        check(req, {7'b0, oe}, 8'h01);
        check(req, d, exp_read(ch, a));
    endtask

    task automatic pins_check(input string req);
        for (int c = 0; c < 2; c++) check(req, {7'b0, mf_n[c]}, {7'b0, exp_pin(c)});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] d; logic oe;
        void'($urandom(32'd2552));
        for (int c = 0; c < 2; c++) begin
            m_line[c] = 0; m_lo[c] = 0; m_hi[c] = 0; m_af[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 oe", {7'b0, rdata_oe}, 8'h00);
        op2_n_i = 2'b01; baud_n_i = 2'b10; rxrdy_n_i = 2'b10;
        #1 pins_check("R1 pins");
        read_check("R1 line", 0, 3'd3);
        read_check("R1 line", 1, 3'd3);

        // R2 line control
        bus_write(0, 3'd3, 8'h5A);
        read_check("R2", 0, 3'd3);
        // R5 other channel untouched
        read_check("R5", 1, 3'd3);

        // R4 identity with zero divisor
        bus_write(1, 3'd3, 8'h80);
        read_check("R4 rev", 1, 3'd0);
        read_check("R4 id", 1, 3'd1);
        // R3 nonzero divisor
        bus_write(1, 3'd0, 8'h0C);
        read_check("R3 lo", 1, 3'd0);
        read_check("R3 hi", 1, 3'd1);
        // back to zero: identity returns in the commit cycle neighbourhood
        bus_write(1, 3'd0, 8'h00);
        read_check("R4 rev again", 1, 3'd0);

        // R10 address 2 and dead addresses
        bus_write(1, 3'd2, 8'hFD);
        read_check("R10 af", 1, 3'd2);
        bus_write(1, 3'd6, 8'hFF);
        read_check("R10 addr6", 1, 3'd6);
        bus_write(0, 3'd1, 8'h33);
        read_check("R10 no dlab", 0, 3'd1);
        bus_write(0, 3'd3, 8'h80);
        read_check("R10 hi untouched", 0, 3'd1);

        // R9 pin mux, all codes on channel 1
        for (int code = 0; code < 4; code++) begin
            bus_write(1, 3'd2, 8'(code));
            for (int s = 0; s < 4; s++) begin
                op2_n_i = 2'(s); baud_n_i = 2'(~s); rxrdy_n_i = 2'(s ^ 1);
                #1 pins_check("R9");
            end
        end

        // R8 commit only after release
        bus_write(0, 3'd2, 8'h00);
        op2_n_i = 2'b00; baud_n_i = 2'b11;
        @(negedge clk);
        chsel = 1'b0; addr = 3'd2; wdata = 8'h01; cs_n = 1'b0;
        @(negedge clk); wr_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 held", {7'b0, mf_n[0]}, 8'h00);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        model_write(0, 3'd2, 8'h01);
        check("R8 released", {7'b0, mf_n[0]}, 8'h01);

        // R6 strobes without select
        @(negedge clk);
        chsel = 1'b0; addr = 3'd3; wdata = 8'hC3; rd_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 no oe", {7'b0, rdata_oe}, 8'h00);
        rd_n = 1'b1; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        read_check("R6 unchanged", 0, 3'd3);

        // R7 idle bus
        check("R7 idle oe", {7'b0, rdata_oe}, 8'h00);
        check("R7 idle data", rdata, 8'h00);

        // random mix, R5 and R4/R3 interplay
        for (int i = 0; i < 80; i++) begin
            int ch = int'($urandom % 2);
            logic [2:0] a = 3'($urandom % 8);
            logic [7:0] v = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
            if (a == 3'd3) v[7] = ($urandom % 4 != 0);
            bus_write(ch, a, v);
            read_check("R5 rand", int'($urandom % 2), 3'($urandom % 4));
            read_check("R4 rand", ch, 3'($urandom % 2));
            op2_n_i = 2'($urandom); baud_n_i = 2'($urandom); rxrdy_n_i = 2'($urandom);
            #1 pins_check("R9 rand");
        end
        bus_read(0, 3'd3, d, oe);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule